// File: doc/BRIEF.md
# Split ECC Queue Buffer

This block is a local word store shared by two transfer channels. A single memory of `DEPTH` words is divided at a programmable split point. The low part is a circular queue for the fetch channel, which carries data read from flash towards the system. The high part is a circular queue for the store channel, which carries data waiting to be written to flash. Each channel pushes and pops its own queue through its own pointers. The two queues never touch each other's words.

Every word is stored with single-error-correct, double-error-detect check bits. These are a Hamming code with an extra overall parity bit. On a pop, a single flipped bit is repaired and flagged on a correctable-error output. A double flip is flagged on an uncorrectable-error output. Each flag is a one-cycle pulse in step with the popped data. For test, an error can be armed so that the next accepted write is stored with one or two bits inverted. An initialisation sweep writes a valid all-zero codeword into every word. It is meant to run before checking is enabled, so that no stale contents raise false flags.

Top module: `split_ecc_buffer`

## Requirements
- R1: After reset both queues report empty and not full. Both read-valid outputs, all error flags, `init_busy` and `init_done` are low.
- R2: With split value P, the fetch queue holds P+1 words and the store queue holds DEPTH-1-P words. Each full output rises once its queue holds that many words. A push while full is dropped.
- R3: A split value above DEPTH-2 acts as DEPTH-2, so each queue always has at least one word. P=0 gives a one-word fetch queue.
- R4: Each queue returns words in the order they were pushed, across any number of pointer wraps. Filling one queue leaves the other queue's contents and flags unchanged.
- R5: A pop accepted at a clock edge puts the word on the read-data output and raises read-valid for exactly the following cycle. A pop on an empty queue produces no read-valid.
- R6: A change of the split value empties both queues by the next clock edge.
- R7: After `inj_one` is pulsed, the next accepted write is stored with data bit 0 inverted. If both channels write in the same cycle, the fetch channel's word takes the error. When that word is popped with `ecc_en` high, the original data is returned and that channel's `err_fix` bit (bit 0 fetch, bit 1 store) pulses with it.
- R8: After `inj_two`, the next accepted write is stored with data bits 0 and 1 inverted. Its pop with `ecc_en` high pulses that channel's `err_bad` bit and leaves `err_fix` low.
- R9: With `ecc_en` low, a pop returns the stored data bits unrepaired and both error flags stay low.
- R10: A pulse on `init_start` while idle holds `init_busy` high for exactly DEPTH cycles. It then raises `init_done`, which stays high until the next sweep starts. The sweep empties both queues. Pushes, pops and further start pulses are ignored while busy.
- R11: An armed error applies to one write only. The write after it is stored clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enables correction and error flags on pops |
| part_sel | input | $clog2(DEPTH) | Split value P; the fetch queue gets P+1 words |
| init_start | input | 1 | Pulse to start the zero-fill sweep |
| init_busy | output | 1 | Sweep in progress |
| init_done | output | 1 | Sweep finished |
| inj_one | input | 1 | Arm a one-bit error for the next write |
| inj_two | input | 1 | Arm a two-bit error for the next write |
| fq_push | input | 1 | Fetch queue push |
| fq_wdata | input | DW | Fetch queue push data |
| fq_full | output | 1 | Fetch queue full |
| fq_empty | output | 1 | Fetch queue empty |
| fq_pop | input | 1 | Fetch queue pop |
| fq_rdata | output | DW | Fetch queue popped data |
| fq_rvalid | output | 1 | Fetch queue popped data valid |
| sq_push | input | 1 | Store queue push |
| sq_wdata | input | DW | Store queue push data |
| sq_full | output | 1 | Store queue full |
| sq_empty | output | 1 | Store queue empty |
| sq_pop | input | 1 | Store queue pop |
| sq_rdata | output | DW | Store queue popped data |
| sq_rvalid | output | 1 | Store queue popped data valid |
| err_fix | output | 2 | Correctable-error pulse per channel |
| err_bad | output | 2 | Uncorrectable-error pulse per channel |

## Verification
The bench builds the block with DEPTH=8 and DW=8, which gives four check bits plus overall parity. This makes every split value reachable, including the clamped one. Each queue is filled past capacity, drained past empty, and wrapped more than twice its size for every split. With 8-bit data, single and double injection run over all 256 data values, so repair and detection are checked against every possible data word at the injected positions.

// File: rtl/seb_pkg.sv
package seb_pkg;
  localparam int N_CH = 2;
  localparam int CH_FETCH = 0;
  localparam int CH_STORE = 1;

  // number of Hamming check bits for a data width (overall parity excluded)
  function automatic int hbits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction
endpackage

// File: rtl/seb_enc.sv
module seb_enc #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]                      din,
  output logic [DW+seb_pkg::hbits(DW):0]     cw
);
  localparam int PB = seb_pkg::hbits(DW);
  localparam int NP = DW + PB;

  logic [PB-1:0] chk;
  logic          ovr;

  always_comb begin
    int idx;
    idx = 0;
    chk = '0;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (din[idx]) chk = chk ^ PB'(p);
        idx++;
      end
    end
    ovr = ^{din, chk};
  end

  assign cw = {ovr, chk, din};
endmodule

// File: rtl/seb_dec.sv
module seb_dec #(
  parameter int DW = 32
) (
  input  logic [DW+seb_pkg::hbits(DW):0] cw,
  input  logic                           ecc_en,
  output logic [DW-1:0]                  dout,
  output logic                           sbe,
  output logic                           dbe
);
  localparam int PB = seb_pkg::hbits(DW);
  localparam int NP = DW + PB;

  logic [DW-1:0] data;
  logic [PB-1:0] chk, syn;
  logic          par, pos_ok;

  assign data = cw[DW-1:0];
  assign chk  = cw[DW+PB-1:DW];

  always_comb begin
    int idx;
    idx = 0;
    syn = chk;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (data[idx]) syn = syn ^ PB'(p);
        idx++;
      end
    end
    par    = ^cw;
    pos_ok = (int'(syn) <= NP);
  end

  always_comb begin
    int idx;
    idx  = 0;
    dout = data;
    if (ecc_en && par && syn != '0 && pos_ok) begin
      for (int p = 1; p <= NP; p++) begin
        if ((p & (p - 1)) != 0) begin
          if (PB'(p) == syn) dout[idx] = ~data[idx];
          idx++;
        end
      end
    end
  end

  assign sbe = ecc_en && par && ((syn == '0) || pos_ok);
  assign dbe = ecc_en && (syn != '0) && (!par || !pos_ok);
endmodule

// File: rtl/seb_ring.sv
module seb_ring #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          stall,
  input  logic [AW-1:0] len_m1,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] woff,
  output logic [AW-1:0] roff,
  output logic          full,
  output logic          empty
);
  logic [AW:0]   cnt_q, cnt_d, cap;
  logic [AW-1:0] w_q, w_d, r_q, r_d;

  assign cap     = {1'b0, len_m1} + (AW+1)'(1);
  assign full    = (cnt_q == cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req && !stall && !clear && !full;
  assign pop_ok  = pop_req && !stall && !clear && !empty;
  assign woff    = w_q;
  assign roff    = r_q;

  always_comb begin
    w_d   = w_q;
    r_d   = r_q;
    cnt_d = cnt_q;
    if (clear) begin
      w_d   = '0;
      r_d   = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) w_d = (w_q == len_m1) ? '0 : w_q + AW'(1);
      if (pop_ok)  r_d = (r_q == len_m1) ? '0 : r_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + (AW+1)'(1);
        2'b01:   cnt_d = cnt_q - (AW+1)'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      r_q   <= '0;
      cnt_q <= '0;
    end else begin
      w_q   <= w_d;
      r_q   <= r_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_ok && !clear) |=> full);
endmodule

// File: rtl/seb_sweep.sv
module seb_sweep #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     start_ok,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(DEPTH)-1:0] waddr
);
  localparam int AW = $clog2(DEPTH);

  logic          busy_q, busy_d, done_q, done_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          last;

  assign start_ok = start && !busy_q;
  assign last     = (cnt_q == AW'(DEPTH - 1));

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    if (start_ok) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + AW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign waddr = cnt_q;

  // R10
  sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);
  // R10
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> (!busy_q && done_q));
endmodule

// File: rtl/seb_mem.sv
module seb_mem #(
  parameter int DEPTH = 128,
  parameter int CW    = 39,
  parameter int NP    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NP-1:0]                         we,
  input  logic [NP-1:0][$clog2(DEPTH)-1:0]      waddr,
  input  logic [NP-1:0][CW-1:0]                 wdata,
  input  logic [NP-1:0][$clog2(DEPTH)-1:0]      raddr,
  output logic [NP-1:0][CW-1:0]                 rdata
);
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (we[i]) mem[waddr[i]] <= wdata[i];
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

  // R4
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && we[1]) |-> (waddr[0] != waddr[1]));
endmodule

// File: rtl/split_ecc_buffer.sv
module split_ecc_buffer #(
  parameter int DEPTH = 128,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ecc_en,
  input  logic [$clog2(DEPTH)-1:0] part_sel,
  input  logic                     init_start,
  output logic                     init_busy,
  output logic                     init_done,
  input  logic                     inj_one,
  input  logic                     inj_two,
  input  logic                     fq_push,
  input  logic [DW-1:0]            fq_wdata,
  output logic                     fq_full,
  output logic                     fq_empty,
  input  logic                     fq_pop,
  output logic [DW-1:0]            fq_rdata,
  output logic                     fq_rvalid,
  input  logic                     sq_push,
  input  logic [DW-1:0]            sq_wdata,
  output logic                     sq_full,
  output logic                     sq_empty,
  input  logic                     sq_pop,
  output logic [DW-1:0]            sq_rdata,
  output logic                     sq_rvalid,
  output logic [1:0]               err_fix,
  output logic [1:0]               err_bad
);
  import seb_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int PB   = hbits(DW);
  localparam int CW   = DW + PB + 1;
  localparam int PMAX = DEPTH - 2;

  // split value and region geometry
  logic [AW-1:0] part_eff, part_q;
  logic          clear;
  logic [N_CH-1:0][AW-1:0] base, len_m1;

  assign part_eff = (part_sel > AW'(PMAX)) ? AW'(PMAX) : part_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) part_q <= '0;
    else        part_q <= part_eff;
  end

  assign base[CH_FETCH]   = '0;
  assign len_m1[CH_FETCH] = part_q;
  assign base[CH_STORE]   = part_q + AW'(1);
  assign len_m1[CH_STORE] = AW'(PMAX) - part_q;

  // initialisation sweep
  logic          sw_start_ok, sw_busy;
  logic [AW-1:0] sw_addr;

  seb_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (init_start),
    .start_ok (sw_start_ok),
    .busy     (sw_busy),
    .done     (init_done),
    .waddr    (sw_addr)
  );
  assign init_busy = sw_busy;
  assign clear     = (part_eff != part_q) || sw_start_ok;

  // per-channel signals
  logic [N_CH-1:0]           push_req, pop_req, push_ok, pop_ok, full_v, empty_v, tgt;
  logic [N_CH-1:0][AW-1:0]   woff, roff, wad, rad;
  logic [N_CH-1:0][DW-1:0]   wdat, rdat_d, rdat_q;
  logic [N_CH-1:0][CW-1:0]   cw_enc, cw_wr, mem_rd;
  logic [N_CH-1:0]           sbe, dbe, rvalid_q, fix_q, bad_q;

  assign push_req = {sq_push, fq_push};
  assign pop_req  = {sq_pop, fq_pop};
  assign wdat[CH_FETCH] = fq_wdata;
  assign wdat[CH_STORE] = sq_wdata;

  // error injection, one-shot on the next accepted write
  logic          pend1_q, pend1_d, pend2_q, pend2_d, wr_evt;
  logic [CW-1:0] flip;

  assign wr_evt  = |push_ok;
  assign pend1_d = (pend1_q && !wr_evt) || inj_one;
  assign pend2_d = (pend2_q && !wr_evt) || inj_two;
  assign flip    = pend2_q ? CW'(3) : (pend1_q ? CW'(1) : '0);
  assign tgt[CH_FETCH] = push_ok[CH_FETCH];
  assign tgt[CH_STORE] = push_ok[CH_STORE] && !push_ok[CH_FETCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
    end else begin
      pend1_q <= pend1_d;
      pend2_q <= pend2_d;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    seb_ring #(.AW(AW)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .stall    (sw_busy),
      .len_m1   (len_m1[c]),
      .push_req (push_req[c]),
      .pop_req  (pop_req[c]),
      .push_ok  (push_ok[c]),
      .pop_ok   (pop_ok[c]),
      .woff     (woff[c]),
      .roff     (roff[c]),
      .full     (full_v[c]),
      .empty    (empty_v[c])
    );

    assign wad[c] = base[c] + woff[c];
    assign rad[c] = base[c] + roff[c];

    seb_enc #(.DW(DW)) u_enc (
      .din (wdat[c]),
      .cw  (cw_enc[c])
    );
    assign cw_wr[c] = cw_enc[c] ^ (tgt[c] ? flip : '0);

    seb_dec #(.DW(DW)) u_dec (
      .cw     (mem_rd[c]),
      .ecc_en (ecc_en),
      .dout   (rdat_d[c]),
      .sbe    (sbe[c]),
      .dbe    (dbe[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rvalid_q[c] <= 1'b0;
        fix_q[c]    <= 1'b0;
        bad_q[c]    <= 1'b0;
      end else begin
        rvalid_q[c] <= pop_ok[c];
        fix_q[c]    <= pop_ok[c] && sbe[c];
        bad_q[c]    <= pop_ok[c] && dbe[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdat_q[c] <= '0;
      else if (pop_ok[c]) rdat_q[c] <= rdat_d[c];
    end

    // R5
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_q[c] |-> $past(pop_req[c]));
    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fix_q[c] && bad_q[c]));
  end

  // shared storage; port 0 is taken by the sweep while it runs
  logic [N_CH-1:0]         m_we;
  logic [N_CH-1:0][AW-1:0] m_wa;
  logic [N_CH-1:0][CW-1:0] m_wd;

  assign m_we[CH_FETCH] = sw_busy || push_ok[CH_FETCH];
  assign m_wa[CH_FETCH] = sw_busy ? sw_addr : wad[CH_FETCH];
  assign m_wd[CH_FETCH] = sw_busy ? '0 : cw_wr[CH_FETCH];
  assign m_we[CH_STORE] = push_ok[CH_STORE];
  assign m_wa[CH_STORE] = wad[CH_STORE];
  assign m_wd[CH_STORE] = cw_wr[CH_STORE];

  seb_mem #(.DEPTH(DEPTH), .CW(CW), .NP(N_CH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (m_we),
    .waddr (m_wa),
    .wdata (m_wd),
    .raddr (rad),
    .rdata (mem_rd)
  );

  assign fq_full   = full_v[CH_FETCH];
  assign fq_empty  = empty_v[CH_FETCH];
  assign fq_rdata  = rdat_q[CH_FETCH];
  assign fq_rvalid = rvalid_q[CH_FETCH];
  assign sq_full   = full_v[CH_STORE];
  assign sq_empty  = empty_v[CH_STORE];
  assign sq_rdata  = rdat_q[CH_STORE];
  assign sq_rvalid = rvalid_q[CH_STORE];
  assign err_fix   = fix_q;
  assign err_bad   = bad_q;

  // R3
  split_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_q <= AW'(PMAX));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_busy |=> (rvalid_q == '0));
  // R9
  ecc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |=> (fix_q == '0 && bad_q == '0));
endmodule

// File: tb/split_ecc_buffer_tb.sv
module split_ecc_buffer_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst_n, ecc_en, init_start, init_busy, init_done, inj_one, inj_two;
  logic [AW-1:0] part_sel;
  logic fq_push, fq_full, fq_empty, fq_pop, fq_rvalid;
  logic sq_push, sq_full, sq_empty, sq_pop, sq_rvalid;
  logic [DW-1:0] fq_wdata, fq_rdata, sq_wdata, sq_rdata;
  logic [1:0] err_fix, err_bad;

  int n_chk = 0;
  int n_bad = 0;

  split_ecc_buffer #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .part_sel(part_sel),
    .init_start(init_start), .init_busy(init_busy), .init_done(init_done),
    .inj_one(inj_one), .inj_two(inj_two),
    .fq_push(fq_push), .fq_wdata(fq_wdata), .fq_full(fq_full), .fq_empty(fq_empty),
    .fq_pop(fq_pop), .fq_rdata(fq_rdata), .fq_rvalid(fq_rvalid),
    .sq_push(sq_push), .sq_wdata(sq_wdata), .sq_full(sq_full), .sq_empty(sq_empty),
    .sq_pop(sq_pop), .sq_rdata(sq_rdata), .sq_rvalid(sq_rvalid),
    .err_fix(err_fix), .err_bad(err_bad)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int p, input int ch, input int i);
    return DW'((p * 37 + i * 13 + ch * 91 + 5) & 255);
  endfunction

  function automatic logic is_full(input int ch);
    return (ch == 0) ? fq_full : sq_full;
  endfunction

  function automatic logic is_empty(input int ch);
    return (ch == 0) ? fq_empty : sq_empty;
  endfunction

  task automatic push(input int ch, input logic [DW-1:0] d);
    if (ch == 0) begin fq_push = 1'b1; fq_wdata = d; end
    else         begin sq_push = 1'b1; sq_wdata = d; end
    tick();
    fq_push = 1'b0;
    sq_push = 1'b0;
  endtask

  task automatic pop(input int ch, output logic [DW-1:0] d, output logic v,
                     output logic fx, output logic bd);
    if (ch == 0) fq_pop = 1'b1; else sq_pop = 1'b1;
    tick();
    fq_pop = 1'b0;
    sq_pop = 1'b0;
    d  = (ch == 0) ? fq_rdata : sq_rdata;
    v  = (ch == 0) ? fq_rvalid : sq_rvalid;
    fx = err_fix[ch];
    bd = err_bad[ch];
  endtask

  task automatic arm(input bit two);
    if (two) inj_two = 1'b1; else inj_one = 1'b1;
    tick();
    inj_one = 1'b0;
    inj_two = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic v, fx, bd;
    int n, pe;
    int sz [2];

    rst_n = 1'b0; ecc_en = 1'b0; init_start = 1'b0; inj_one = 1'b0; inj_two = 1'b0;
    part_sel = '0; fq_push = 1'b0; sq_push = 1'b0; fq_pop = 1'b0; sq_pop = 1'b0;
    fq_wdata = '0; sq_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(fq_empty && sq_empty && !fq_full && !sq_full, "R1 empty/full", {fq_empty, sq_empty, fq_full, sq_full}, 4'b1100);
    chk(!fq_rvalid && !sq_rvalid && err_fix == 0 && err_bad == 0, "R1 valid/flags",
        {fq_rvalid, sq_rvalid, err_fix, err_bad}, 0);
    chk(!init_busy && !init_done, "R1 sweep idle", {init_busy, init_done}, 0);

    // R10 sweep with a push held on and a repeated start
    fq_push = 1'b1; fq_wdata = 8'h11;
    init_start = 1'b1;
    tick();
    init_start = 1'b0;
    n = 0;
    while (init_busy && n < 1000) begin
      n++;
      init_start = (n == 3);
      tick();
    end
    init_start = 1'b0;
    fq_push = 1'b0;
    chk(n == DEPTH, "R10 busy length", n, DEPTH);
    chk(init_done == 1'b1, "R10 done flag", init_done, 1);
    chk(fq_empty == 1'b1, "R10 pushes ignored while busy", fq_empty, 1);
    ecc_en = 1'b1;

    // R2 R3 R4 R5 over every split value
    for (int p = 0; p < DEPTH; p++) begin
      part_sel = AW'(p);
      tick();
      tick();
      pe = (p > DEPTH - 2) ? DEPTH - 2 : p;
      sz[0] = pe + 1;
      sz[1] = DEPTH - 1 - pe;
      for (int ch = 0; ch < 2; ch++) begin
        for (int i = 0; i < DEPTH; i++) push(ch, pat(p, ch, i));
        chk(is_full(ch) == 1'b1, (p == DEPTH - 1) ? "R3 clamped region full" : "R2 full flag", is_full(ch), 1);
        chk(is_empty(1 - ch) == 1'b1, "R4 other queue untouched", is_empty(1 - ch), 1);
        for (int i = 0; i < DEPTH; i++) begin
          pop(ch, d, v, fx, bd);
          chk(v == (i < sz[ch]), (p == DEPTH - 1) ? "R3 capacity" : "R2 capacity", v, (i < sz[ch]));
          if (i < sz[ch]) chk(d == pat(p, ch, i), "R4 order", d, pat(p, ch, i));
        end
        chk(is_empty(ch) == 1'b1, "R5 empty after drain", is_empty(ch), 1);
        for (int i = 0; i < 2 * sz[ch] + 1; i++) begin
          push(ch, pat(p, ch, i + 50));
          pop(ch, d, v, fx, bd);
          chk(v && d == pat(p, ch, i + 50) && !fx && !bd, "R4 wrap", d, pat(p, ch, i + 50));
        end
      end
    end

    // R6 split change empties both queues
    part_sel = 3'd3;
    tick();
    tick();
    push(0, 8'h21);
    push(1, 8'h22);
    part_sel = 3'd2;
    tick();
    chk(fq_empty && sq_empty, "R6 queues emptied", {fq_empty, sq_empty}, 2'b11);
    part_sel = 3'd3;
    tick();
    tick();

    // R7 single injection corrected and flagged, R11 one-shot
    arm(1'b0);
    push(0, 8'hA5);
    pop(0, d, v, fx, bd);
    chk(v && d == 8'hA5, "R7 corrected data", d, 8'hA5);
    chk(fx && !bd, "R7 fix flag", {fx, bd}, 2'b10);
    push(0, 8'h5A);
    pop(0, d, v, fx, bd);
    chk(d == 8'h5A && !fx && !bd, "R11 next write clean", {fx, bd}, 0);

    // R7 fetch takes the error on a simultaneous write; R9 raw data with ecc off
    ecc_en = 1'b0;
    arm(1'b0);
    fq_push = 1'b1; sq_push = 1'b1; fq_wdata = 8'h40; sq_wdata = 8'h40;
    tick();
    fq_push = 1'b0; sq_push = 1'b0;
    pop(0, d, v, fx, bd);
    chk(d == 8'h41, "R7 fetch channel takes error", d, 8'h41);
    chk(!fx && !bd, "R9 no flags with ecc off", {fx, bd}, 0);
    pop(1, d, v, fx, bd);
    chk(d == 8'h40, "R7 store word clean", d, 8'h40);
    arm(1'b1);
    push(1, 8'hF0);
    pop(1, d, v, fx, bd);
    chk(d == 8'hF3 && !fx && !bd, "R9 raw double flip", d, 8'hF3);
    ecc_en = 1'b1;

    // R7 and R8 exhaustive over data values
    n = 0;
    for (int x = 0; x < 256; x++) begin
      arm(1'b0);
      push(0, DW'(x));
      pop(0, d, v, fx, bd);
      if (!(v && d == DW'(x) && fx && !bd)) n++;
    end
    chk(n == 0, "R7 sweep of single-bit repair", n, 0);
    n = 0;
    for (int x = 0; x < 256; x++) begin
      arm(1'b1);
      push(1, DW'(x));
      pop(1, d, v, fx, bd);
      if (!(v && bd && !fx)) n++;
    end
    chk(n == 0, "R8 sweep of double-bit detect", n, 0);

    summary();
    $finish;
  end
endmodule